// File: doc/BRIEF.md
# Two-Level Interrupt Collector

This block gathers event pulses from a fixed set of functional sources into one interrupt line for a host processor. Each source owns an 8-bit status register whose bits latch when the matching event input pulses. Each status bit stays set until the host writes a one to it. Each source also owns an 8-bit mute register. A mute bit of one keeps the matching status bit from reaching the interrupt line, and a mute value of 0xFF silences the whole source.

The status registers sit in a contiguous window starting at offset 0x100, one per source, in source order. Each mute register sits 0x80 above its status register. A separate global mute register at offset 0x1FF has two bits. Bit 0 silences the interrupt line and bit 1 silences the wakeup line. Both output lines come from the same pending set, so either can be gated alone.

The host uses a byte-wide port. A write happens on any clock edge where the write strobe is high. A read is combinational from the address. Status bits keep latching while they are muted. Unmuting a pending bit therefore raises the interrupt straight away.

Top module: `intc_collector`

## Requirements
- R1: After reset, every status register reads 0x00, every mute register reads 0xFF, the global mute register reads 0x03, and irq_o and wake_o are low.
- R2: An event pulse on bit b of source s sets bit b of the status register at offset 0x100+s. The bit stays set through later cycles until it is cleared.
- R3: A write to a status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set. Other bits named in that write are still cleared.
- R5: The mute register of source s sits at offset 0x180+s. It reads back the value last written to it.
- R6: irq_o is high exactly when some status bit is set, its mute bit is 0, and global mute bit 0 is 0.
- R7: Status bits latch while muted. Writing a mute value that exposes a pending bit raises irq_o in the cycle right after the write edge.
- R8: wake_o is high exactly when some status bit is set, its mute bit is 0, and global mute bit 1 is 0. wake_o does not depend on global mute bit 0.
- R9: The global mute register keeps only write-data bits 1:0 and reads its upper bits as 0. Addresses outside the mapped registers read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_ev | input | NUM_SRC*DW | Event pulses; source s uses bits [s*DW +: DW] |
| reg_addr | input | ADDR_W | Register offset for reads and writes |
| reg_wr | input | 1 | Write strobe; the write is taken at the rising edge |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr, combinational |
| irq_o | output | 1 | Host interrupt line |
| wake_o | output | 1 | Wakeup indication line |

## Verification
Every register sits one flop away from its inputs. The two output lines and the read data are combinational from those flops. A write or event applied before a rising edge is therefore visible on reg_rdata, irq_o and wake_o in the cycle after that edge, with zero further delay. The bench drives each stimulus on a falling edge and lets one rising edge pass. It drops the strobes and moves the address on the next falling edge, then samples a moment later. Each check sees exactly the one edge its requirement describes. The same-cycle set and clear case of R4 is driven in a single cycle so that both reach the same edge.

// File: rtl/intc_pkg.sv
package intc_pkg;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_STAT = 2'd1,
      SEL_MUTE = 2'd2,
      SEL_GLOB = 2'd3
   } intc_sel_e;

   localparam int GLOB_BITS = 2;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/intc_src_slice.sv
module intc_src_slice #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] ev,
   input  logic          stat_we,
   input  logic          mute_we,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] stat_q,
   output logic [DW-1:0] mute_q,
   output logic          pend
);

   logic [DW-1:0] clr_mask;

   always_comb begin
      clr_mask = stat_we ? wdata : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         mute_q <= '1;
      end else begin
         stat_q <= (stat_q & ~clr_mask) | ev;
         if (mute_we) begin
            mute_q <= wdata;
         end
      end
   end

   assign pend = |(stat_q & ~mute_q);

endmodule

// File: rtl/intc_decode.sv
module intc_decode
   import intc_pkg::*;
#(
   parameter int ADDR_W    = 9,
   parameter int NUM_SRC   = 10,
   parameter int STAT_BASE = 'h100,
   parameter int MUTE_OFS  = 'h80,
   parameter int GLOB_ADDR = 'h1FF,
   localparam int IDX_W    = idx_width(NUM_SRC)
) (
   input  logic [ADDR_W-1:0] addr,
   output intc_sel_e         sel,
   output logic [IDX_W-1:0]  idx
);

   localparam int MUTE_BASE = STAT_BASE + MUTE_OFS;

   int a;

   always_comb begin
      a   = int'(addr);
      sel = SEL_NONE;
      idx = '0;
      if (a == GLOB_ADDR) begin
         sel = SEL_GLOB;
      end else if (a >= STAT_BASE && a < STAT_BASE + NUM_SRC) begin
         sel = SEL_STAT;
         idx = IDX_W'(a - STAT_BASE);
      end else if (a >= MUTE_BASE && a < MUTE_BASE + NUM_SRC) begin
         sel = SEL_MUTE;
         idx = IDX_W'(a - MUTE_BASE);
      end
   end

endmodule

// File: rtl/intc_combine.sv
module intc_combine
   import intc_pkg::*;
#(
   parameter int NUM_SRC = 10,
   parameter bit OUT_REG = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SRC-1:0]   pend,
   input  logic [GLOB_BITS-1:0] glob,
   output logic                 irq,
   output logic                 wake
);

   logic any_pend;
   logic irq_d;
   logic wake_d;

   assign any_pend = |pend;
   assign irq_d    = any_pend & ~glob[0];
   assign wake_d   = any_pend & ~glob[1];

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq  <= 1'b0;
               wake <= 1'b0;
            end else begin
               irq  <= irq_d;
               wake <= wake_d;
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign irq  = irq_d;
         assign wake = wake_d;
      end
   endgenerate

endmodule

// File: rtl/intc_collector.sv
module intc_collector
   import intc_pkg::*;
#(
   parameter int NUM_SRC   = 10,
   parameter int DW        = 8,
   parameter int ADDR_W    = 9,
   parameter int STAT_BASE = 'h100,
   parameter int MUTE_OFS  = 'h80,
   parameter int GLOB_ADDR = 'h1FF,
   parameter bit OUT_REG   = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_SRC*DW-1:0] src_ev,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic                  reg_wr,
   input  logic [DW-1:0]         reg_wdata,
   output logic [DW-1:0]         reg_rdata,
   output logic                  irq_o,
   output logic                  wake_o
);

   localparam int IDX_W = idx_width(NUM_SRC);

   if (DW < GLOB_BITS) begin : g_bad_dw
      $error("DW must hold the global mute bits");
   end
   if (NUM_SRC < 1 || NUM_SRC > MUTE_OFS) begin : g_bad_src
      $error("NUM_SRC must be between 1 and MUTE_OFS");
   end
   if (GLOB_ADDR >= STAT_BASE && GLOB_ADDR < STAT_BASE + MUTE_OFS + NUM_SRC
       && !(GLOB_ADDR >= STAT_BASE + NUM_SRC && GLOB_ADDR < STAT_BASE + MUTE_OFS)) begin : g_bad_glob
      $error("GLOB_ADDR overlaps a per-source register");
   end
   if (STAT_BASE + MUTE_OFS + NUM_SRC > (1 << ADDR_W)) begin : g_bad_aw
      $error("ADDR_W too narrow for the register window");
   end

   intc_sel_e             sel;
   logic [IDX_W-1:0]      idx;
   logic [NUM_SRC*DW-1:0] stat_all;
   logic [NUM_SRC*DW-1:0] mute_all;
   logic [NUM_SRC-1:0]    pend;
   logic [GLOB_BITS-1:0]  glob_q;

   intc_decode #(
      .ADDR_W   (ADDR_W),
      .NUM_SRC  (NUM_SRC),
      .STAT_BASE(STAT_BASE),
      .MUTE_OFS (MUTE_OFS),
      .GLOB_ADDR(GLOB_ADDR)
   ) u_dec (
      .addr(reg_addr),
      .sel (sel),
      .idx (idx)
   );

   generate
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
         logic hit;
         assign hit = reg_wr && (int'(idx) == s);
         intc_src_slice #(.DW(DW)) u_slice (
            .clk    (clk),
            .rst_n  (rst_n),
            .ev     (src_ev[s*DW +: DW]),
            .stat_we(hit && sel == SEL_STAT),
            .mute_we(hit && sel == SEL_MUTE),
            .wdata  (reg_wdata),
            .stat_q (stat_all[s*DW +: DW]),
            .mute_q (mute_all[s*DW +: DW]),
            .pend   (pend[s])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         glob_q <= '1;
      end else if (reg_wr && sel == SEL_GLOB) begin
         glob_q <= reg_wdata[GLOB_BITS-1:0];
      end
   end

   always_comb begin
      case (sel)
         SEL_STAT: reg_rdata = stat_all[int'(idx)*DW +: DW];
         SEL_MUTE: reg_rdata = mute_all[int'(idx)*DW +: DW];
         SEL_GLOB: reg_rdata = DW'(glob_q);
         default:  reg_rdata = '0;
      endcase
   end

   intc_combine #(
      .NUM_SRC(NUM_SRC),
      .OUT_REG(OUT_REG)
   ) u_comb (
      .clk  (clk),
      .rst_n(rst_n),
      .pend (pend),
      .glob (glob_q),
      .irq  (irq_o),
      .wake (wake_o)
   );

endmodule

// File: rtl/intc_collector_chk.sv
module intc_collector_chk #(
   parameter int NUM_SRC = 10,
   parameter int DW      = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NUM_SRC*DW-1:0] src_ev,
   input logic                  reg_wr,
   input logic [NUM_SRC*DW-1:0] stat_all,
   input logic [NUM_SRC*DW-1:0] mute_all,
   input logic [1:0]            glob_q,
   input logic                  irq_o,
   input logic                  wake_o
);

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!irq_o && !wake_o)); // R1

   AST_STICKY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(reg_wr)) |-> ((stat_all & $past(stat_all)) == $past(stat_all))); // R2

   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((stat_all & $past(src_ev)) == $past(src_ev))); // R4

   AST_GLOBAL_IRQ_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
      glob_q[0] |-> !irq_o); // R6

   AST_GLOBAL_WAKE_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
      glob_q[1] |-> !wake_o); // R8

   AST_NO_PENDING_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_all & ~mute_all) == '0) |-> (!irq_o && !wake_o)); // R6

   AST_UNMUTED_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (((stat_all & ~mute_all) != '0) && !glob_q[0]) |-> irq_o); // R7

endmodule

bind intc_collector intc_collector_chk #(
   .NUM_SRC(NUM_SRC),
   .DW     (DW)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .src_ev  (src_ev),
   .reg_wr  (reg_wr),
   .stat_all(stat_all),
   .mute_all(mute_all),
   .glob_q  (glob_q),
   .irq_o   (irq_o),
   .wake_o  (wake_o)
);

// File: tb/intc_collector_bench.sv
module intc_collector_bench;

   localparam int NS = 10;
   localparam int DW = 8;
   localparam int AW = 9;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NS*DW-1:0] src_ev = '0;
   logic [AW-1:0]    reg_addr = '0;
   logic             reg_wr = 1'b0;
   logic [DW-1:0]    reg_wdata = '0;
   logic [DW-1:0]    reg_rdata;
   logic             irq_o;
   logic             wake_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   intc_collector u_intc_collector (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_ev   (src_ev),
      .reg_addr (reg_addr),
      .reg_wr   (reg_wr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .irq_o    (irq_o),
      .wake_o   (wake_o)
   );

   typedef struct packed {
      logic       op;
      logic [8:0] addr;
      logic [3:0] src;
      logic [7:0] data;
      logic [8:0] chk;
      logic [7:0] exp_rd;
      logic       exp_irq;
      logic       exp_wake;
      logic [3:0] req;
   } vec_t;

   localparam logic WR = 1'b0;
   localparam logic EV = 1'b1;

   localparam int NV = 16;
   localparam vec_t TBL [NV] = '{
      '{WR, 9'h1FF, 4'd0, 8'h00, 9'h1FF, 8'h00, 1'b0, 1'b0, 4'd6}, // R6 global open, nothing pending
      '{EV, 9'h000, 4'd4, 8'h01, 9'h104, 8'h01, 1'b0, 1'b0, 4'd7}, // R7 latch while muted, R2
      '{WR, 9'h184, 4'd0, 8'hFE, 9'h184, 8'hFE, 1'b1, 1'b1, 4'd7}, // R7 unmute raises, R5
      '{WR, 9'h104, 4'd0, 8'h00, 9'h104, 8'h01, 1'b1, 1'b1, 4'd3}, // R3 write zero keeps
      '{WR, 9'h104, 4'd0, 8'h01, 9'h104, 8'h00, 1'b0, 1'b0, 4'd3}, // R3 write one clears
      '{EV, 9'h000, 4'd5, 8'h03, 9'h105, 8'h03, 1'b0, 1'b0, 4'd2}, // R2
      '{WR, 9'h185, 4'd0, 8'hFD, 9'h185, 8'hFD, 1'b1, 1'b1, 4'd5}, // R5
      '{WR, 9'h105, 4'd0, 8'h02, 9'h105, 8'h01, 1'b0, 1'b0, 4'd6}, // R6 only muted bit left
      '{WR, 9'h1FF, 4'd0, 8'h01, 9'h1FF, 8'h01, 1'b0, 1'b0, 4'd9}, // R9
      '{EV, 9'h000, 4'd5, 8'h02, 9'h105, 8'h03, 1'b0, 1'b1, 4'd8}, // R8 wake despite irq mute
      '{WR, 9'h1FF, 4'd0, 8'h02, 9'h1FF, 8'h02, 1'b1, 1'b0, 4'd8}, // R8 wake muted alone
      '{WR, 9'h1FF, 4'd0, 8'hFC, 9'h1FF, 8'h00, 1'b1, 1'b1, 4'd9}, // R9 upper bits dropped
      '{WR, 9'h0FF, 4'd0, 8'h55, 9'h0FF, 8'h00, 1'b1, 1'b1, 4'd9}, // R9 unmapped
      '{WR, 9'h10A, 4'd0, 8'hFF, 9'h10A, 8'h00, 1'b1, 1'b1, 4'd9}, // R9 past last source
      '{EV, 9'h000, 4'd9, 8'h80, 9'h109, 8'h80, 1'b1, 1'b1, 4'd2}, // R2 last source
      '{WR, 9'h189, 4'd0, 8'h7F, 9'h189, 8'h7F, 1'b1, 1'b1, 4'd5}  // R5 last source
   };

   task automatic check8(input int req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic op, input logic [8:0] addr, input int src,
                        input logic [7:0] data, input logic [8:0] chk);
      @(negedge clk);
      if (op == EV) begin
         src_ev[src*DW +: DW] = data;
      end else begin
         reg_addr  = addr;
         reg_wdata = data;
         reg_wr    = 1'b1;
      end
      @(negedge clk);
      reg_wr   = 1'b0;
      src_ev   = '0;
      reg_addr = chk;
      #1;
   endtask

   task automatic read_chk(input int req, input logic [8:0] addr, input logic [7:0] exp);
      reg_addr = addr;
      #1;
      check8(req, $sformatf("read %h", addr), reg_rdata, exp);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int s = 0; s < NS; s++) begin
         read_chk(1, 9'(9'h100 + s), 8'h00);
         read_chk(1, 9'(9'h180 + s), 8'hFF);
      end
      read_chk(1, 9'h1FF, 8'h03);
      check8(1, "irq after reset", {7'd0, irq_o}, 8'h00);
      check8(1, "wake after reset", {7'd0, wake_o}, 8'h00);

      for (int i = 0; i < NV; i++) begin
         apply(TBL[i].op, TBL[i].addr, int'(TBL[i].src), TBL[i].data, TBL[i].chk);
         check8(int'(TBL[i].req), $sformatf("vec %0d rdata", i), reg_rdata, TBL[i].exp_rd);
         check8(int'(TBL[i].req), $sformatf("vec %0d irq", i), {7'd0, irq_o}, {7'd0, TBL[i].exp_irq});
         check8(int'(TBL[i].req), $sformatf("vec %0d wake", i), {7'd0, wake_o}, {7'd0, TBL[i].exp_wake});
      end

      // R4 set wins over same-cycle clear; other cleared bits still clear
      apply(EV, 9'h000, 0, 8'h02, 9'h100);
      check8(2, "src0 bit1 latched", reg_rdata, 8'h02);
      @(negedge clk);
      src_ev[7:0] = 8'h01;
      reg_addr    = 9'h100;
      reg_wdata   = 8'h03;
      reg_wr      = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      src_ev = '0;
      #1;
      check8(4, "set wins, other bit cleared", reg_rdata, 8'h01);
      @(negedge clk);
      src_ev[7:0] = 8'h01;
      reg_wdata   = 8'h01;
      reg_wr      = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      src_ev = '0;
      #1;
      check8(4, "set wins same bit", reg_rdata, 8'h01);

      // R9 write to unused mute slot touches no register
      apply(WR, 9'h18A, 0, 8'h00, 9'h18A);
      check8(9, "unused mute slot", reg_rdata, 8'h00);
      read_chk(9, 9'h180, 8'hFF);
      read_chk(9, 9'h109, 8'h80);

      // R1 reset again mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      read_chk(1, 9'h109, 8'h00);
      read_chk(1, 9'h189, 8'hFF);
      read_chk(1, 9'h1FF, 8'h03);
      check8(1, "irq after second reset", {7'd0, irq_o}, 8'h00);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule